// File: doc/BRIEF.md
# Transaction Handoff Buffer with Control Token

This block is a first-in first-out store of whole transactions placed between a stimulus producer and a hardware-side consumer, such as a bus driver feeding a design under test. Beyond buffering, it holds a two-party control token that says which side is currently allowed to run. The producer fills the store while it holds the token. The consumer drains it while it holds the token. The token moves on its own at the natural boundaries, so neither side has to negotiate the switch.

The token passes to the consumer when the store reaches its configured fill level, or when the producer yields with work pending. It comes back to the producer when the store runs dry, or earlier when the consumer raises an attention pulse because it has seen a state the producer should react to. Transactions left in the store at that moment are kept, and they are the first ones delivered once the consumer runs again.

The fill level that counts as full can be changed for each test at run time. The new value takes effect only while the store is empty. Every change of ownership is counted, so the rate of context switches can be measured.

Top module: `txn_handoff_port`

## Requirements
- R1: After a synchronous reset, `owner` is 0 (producer), `empty` is 1, `full` is 0, `handoff_cnt` is 0 and `yield_err` is 0.
- R2: A write is accepted only when `prod_valid` is high, `owner` is 0 and `full` is low. `prod_ready` shows exactly that acceptance condition. At all other times, writes leave the stored contents unchanged.
- R3: `full` is high when the number of stored transactions equals the current depth limit. While `owner` is 0 and `full` is high, `owner` becomes 1 (consumer) at the next clock edge. No write beyond the limit is accepted.
- R4: `cons_valid` is high exactly when `owner` is 1 and the store is not empty. A read happens when `cons_valid` and `cons_ready` are both high. `cons_data` presents the oldest stored transaction, so transactions leave in the order they were written.
- R5: While `owner` is 1 and the store is empty, `owner` returns to 0 at the next clock edge.
- R6: An `attn` pulse seen while `owner` is 1 sets `owner` to 0 at the next clock edge. The stored transactions are kept and are delivered first when the consumer runs again.
- R7: The depth limit is loaded from `cfg_depth` at every clock edge where the store is empty, and it is held otherwise. A value of 0 is taken as 1, and a value above MAX_DEPTH is taken as MAX_DEPTH. After reset the limit is MAX_DEPTH.
- R8: `prod_yield` while `owner` is 0 and the store is not empty sets `owner` to 1 at the next clock edge.
- R9: `prod_yield` while `owner` is 0 and the store is empty raises `yield_err` for exactly the following cycle, and `owner` stays 0.
- R10: `handoff_cnt` increases by one on every change of `owner` and wraps modulo 2^HCNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | $clog2(MAX_DEPTH+1) | Requested fill level that counts as full |
| prod_valid | input | 1 | Producer offers a transaction |
| prod_data | input | DATA_W | Transaction from the producer |
| prod_ready | output | 1 | Offered transaction is accepted this cycle |
| prod_yield | input | 1 | Producer hands control over |
| cons_data | output | DATA_W | Oldest stored transaction |
| cons_valid | output | 1 | A transaction is available to the consumer |
| cons_ready | input | 1 | Consumer takes the transaction |
| attn | input | 1 | Consumer requests producer attention |
| owner | output | 1 | Control token: 0 producer, 1 consumer |
| full | output | 1 | Fill level equals the depth limit |
| empty | output | 1 | No transaction stored |
| handoff_cnt | output | HCNT_W | Count of ownership changes |
| yield_err | output | 1 | Yield attempted on an empty store |

## Verification
The bench builds the block with MAX_DEPTH set to 5, DATA_W set to 16 and HCNT_W set to 4. A depth of 5 is not a power of two, so the pointer path with explicit wrap is used, and the limit reaches its cap after only a few writes. A 3-bit `cfg_depth` can request 0, 6 and 7, which exercises clamping at both ends. A 4-bit counter wraps many times during the random phase, so R10 wrap-around is exercised.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic {
        OWN_PROD = 1'b0,
        OWN_CONS = 1'b1
    } owner_e;

    // Events that steer the control token in one cycle
    typedef struct packed {
        logic full;
        logic empty;
        logic yield;
        logic attn;
    } tok_evt_t;

    // Store request for one cycle
    typedef struct packed {
        logic wr;
        logic rd;
    } xfer_t;

    function automatic int clamp_limit(input int req, input int maxd);
        if (req < 1)
            return 1;
        else if (req > maxd)
            return maxd;
        else
            return req;
    endfunction

endpackage

// File: rtl/hp_store.sv
module hp_store
    import hp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit POW2 = (DEPTH == (1 << AW));

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q, rp_q, wp_nx, rp_nx;

    generate
        if (POW2) begin : g_natural_wrap
            assign wp_nx = wp_q + AW'(1);
            assign rp_nx = rp_q + AW'(1);
        end else begin : g_compare_wrap
            assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (req.wr) wp_q <= wp_nx;
            if (req.rd) rp_q <= rp_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (req.wr) mem[wp_q] <= wr_data;
    end

    assign rd_data = mem[rp_q];

    // R4
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wp_q) < DEPTH) && (int'(rp_q) < DEPTH));

endmodule

// File: rtl/hp_level.sv
module hp_level
    import hp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_t         req,
    input  logic [CW-1:0] cfg_depth,
    output logic          full,
    output logic          empty
);
    logic [CW-1:0] count_q, lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case ({req.wr, req.rd})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Limit follows the request only while nothing is stored
    always_ff @(posedge clk) begin
        if (rst)
            lim_q <= CW'(DEPTH);
        else if (count_q == '0)
            lim_q <= CW'(clamp_limit(int'(cfg_depth), DEPTH));
    end

    assign empty = (count_q == '0);
    assign full  = (count_q >= lim_q);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= lim_q);

    // R7
    limit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (lim_q >= CW'(1)) && (int'(lim_q) <= DEPTH));

    // R7
    limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0) |=> $stable(lim_q));

endmodule

// File: rtl/hp_token.sv
module hp_token
    import hp_pkg::*;
#(
    parameter int HCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  tok_evt_t          evt,
    output owner_e            owner,
    output logic [HCNT_W-1:0] handoff_cnt,
    output logic              yield_err
);
    owner_e            own_q, own_nx;
    logic [HCNT_W-1:0] cnt_q;
    logic              err_q, err_nx;

    always_comb begin
        own_nx = own_q;
        err_nx = 1'b0;
        unique case (own_q)
            OWN_PROD: begin
                if (evt.full)
                    own_nx = OWN_CONS;
                else if (evt.yield && !evt.empty)
                    own_nx = OWN_CONS;
                else if (evt.yield)
                    err_nx = 1'b1;
            end
            OWN_CONS: begin
                if (evt.attn || evt.empty)
                    own_nx = OWN_PROD;
            end
            default: own_nx = OWN_PROD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= OWN_PROD;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            own_q <= own_nx;
            err_q <= err_nx;
            if (own_nx != own_q) cnt_q <= cnt_q + HCNT_W'(1);
        end
    end

    assign owner       = own_q;
    assign handoff_cnt = cnt_q;
    assign yield_err   = err_q;

    // R10
    handoff_count_chk: assert property (@(posedge clk) disable iff (rst)
        (own_q != $past(own_q)) |-> (cnt_q == $past(cnt_q) + HCNT_W'(1)));

    // R10
    handoff_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (own_q == $past(own_q)) |-> (cnt_q == $past(cnt_q)));

    // R9
    yield_err_keep_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (own_q == OWN_PROD && $past(own_q) == OWN_PROD));

endmodule

// File: rtl/txn_handoff_port.sv
module txn_handoff_port
    import hp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MAX_DEPTH = 16,
    parameter int HCNT_W    = 16,
    localparam int CW       = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cfg_depth,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_data,
    output logic              prod_ready,
    input  logic              prod_yield,
    output logic [DATA_W-1:0] cons_data,
    output logic              cons_valid,
    input  logic              cons_ready,
    input  logic              attn,
    output logic              owner,
    output logic              full,
    output logic              empty,
    output logic [HCNT_W-1:0] handoff_cnt,
    output logic              yield_err
);
    owner_e   own;
    xfer_t    req;
    tok_evt_t evt;
    logic     lvl_full, lvl_empty;

    assign prod_ready = (own == OWN_PROD) && !lvl_full;
    assign cons_valid = (own == OWN_CONS) && !lvl_empty;
    assign req.wr     = prod_valid && prod_ready;
    assign req.rd     = cons_ready && cons_valid;

    assign evt.full  = lvl_full;
    assign evt.empty = lvl_empty;
    assign evt.yield = prod_yield;
    assign evt.attn  = attn;

    hp_store #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr_data (prod_data),
        .rd_data (cons_data)
    );

    hp_level #(.DEPTH(MAX_DEPTH), .CW(CW)) u_level (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cfg_depth (cfg_depth),
        .full      (lvl_full),
        .empty     (lvl_empty)
    );

    hp_token #(.HCNT_W(HCNT_W)) u_token (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .owner       (own),
        .handoff_cnt (handoff_cnt),
        .yield_err   (yield_err)
    );

    assign owner = own;
    assign full  = lvl_full;
    assign empty = lvl_empty;

    // R2
    write_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && prod_ready) |-> (owner == 1'b0 && !full));

    // R4
    read_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && cons_ready) |-> (owner == 1'b1 && !empty));

    // R3
    full_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == 1'b0 && full) |=> (owner == 1'b1));

    // R5
    drain_return_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == 1'b1 && empty) |=> (owner == 1'b0));

    // R6
    attn_return_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == 1'b1 && attn) |=> (owner == 1'b0));

    // R8
    yield_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (owner == 1'b0 && prod_yield && !empty) |=> (owner == 1'b1));

endmodule

// File: tb/txn_handoff_port_test.sv
`timescale 1ns/1ps
module txn_handoff_port_test;
    localparam int DW   = 16;
    localparam int MAXD = 5;
    localparam int HW   = 4;
    localparam int CW   = $clog2(MAXD + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_depth = '0;
    logic          prod_valid = 1'b0;
    logic [DW-1:0] prod_data = '0;
    logic          prod_ready;
    logic          prod_yield = 1'b0;
    logic [DW-1:0] cons_data;
    logic          cons_valid;
    logic          cons_ready = 1'b0;
    logic          attn = 1'b0;
    logic          owner, full, empty, yield_err;
    logic [HW-1:0] handoff_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference state
    logic [DW-1:0] m_q[$];
    int            m_lim;
    logic          m_own;
    int            m_cnt;
    logic          m_err;
    logic [DW-1:0] next_word = 16'h1000;

    always #2.5 clk = ~clk;

    txn_handoff_port #(.DATA_W(DW), .MAX_DEPTH(MAXD), .HCNT_W(HW)) uut (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
        .prod_valid(prod_valid), .prod_data(prod_data), .prod_ready(prod_ready),
        .prod_yield(prod_yield), .cons_data(cons_data), .cons_valid(cons_valid),
        .cons_ready(cons_ready), .attn(attn), .owner(owner), .full(full),
        .empty(empty), .handoff_cnt(handoff_cnt), .yield_err(yield_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic m_full, m_empty;
        m_empty = (m_q.size() == 0);
        m_full  = (m_q.size() >= m_lim);
        chk("R2 prod_ready", 32'(prod_ready), 32'(!m_own && !m_full));
        chk("R4 cons_valid", 32'(cons_valid), 32'(m_own && !m_empty));
        if (m_own && !m_empty) chk("R4 cons_data order", 32'(cons_data), 32'(m_q[0]));
        chk("R3/R5/R6/R8 owner", 32'(owner), 32'(m_own));
        chk("R3/R7 full", 32'(full), 32'(m_full));
        chk("R5 empty", 32'(empty), 32'(m_empty));
        chk("R10 handoff_cnt", 32'(handoff_cnt), 32'(m_cnt % (1 << HW)));
        chk("R9 yield_err", 32'(yield_err), 32'(m_err));
    endtask

    // One clock: drive inputs, advance the model, compare at the next falling edge
    task automatic step(input logic pv, input logic py, input logic cr,
                        input logic at, input int cd);
        logic m_full, m_empty, wf, rf, n_own, n_err;
        prod_valid = pv;
        prod_data  = next_word;
        prod_yield = py;
        cons_ready = cr;
        attn       = at;
        cfg_depth  = CW'(cd);
        m_empty = (m_q.size() == 0);
        m_full  = (m_q.size() >= m_lim);
        wf = pv && !m_own && !m_full;
        rf = cr && m_own && !m_empty;
        n_own = m_own;
        n_err = 1'b0;
        if (!m_own) begin
            if (m_full) n_own = 1'b1;
            else if (py && !m_empty) n_own = 1'b1;
            else if (py) n_err = 1'b1;
        end else if (at || m_empty) begin
            n_own = 1'b0;
        end
        @(posedge clk);
        if (m_empty) m_lim = (cd < 1) ? 1 : ((cd > MAXD) ? MAXD : cd);
        if (rf) void'(m_q.pop_front());
        if (wf) begin
            m_q.push_back(next_word);
            next_word = next_word + 16'h0013;
        end
        if (n_own != m_own) m_cnt++;
        m_own = n_own;
        m_err = n_err;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_lim = MAXD; m_own = 1'b0; m_cnt = 0; m_err = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 owner", 32'(owner), 32'd0);
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 handoff_cnt", 32'(handoff_cnt), 32'd0);
        chk("R1 yield_err", 32'(yield_err), 32'd0);

        // R3 R7: limit 3, the fourth write is refused, token moves to consumer
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 3);
        // R2: writes offered while the consumer owns are ignored
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 3);
        // R4 R5: drain in order, token returns when empty
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 3);
        // R9: yield on an empty store
        step(0, 1, 0, 0, 3);
        step(0, 0, 0, 0, 3);
        // R7: limit 0 acts as 1
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
        // R7: limit above the maximum is capped
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 7);
        // R6: two reads, then attention; remaining data kept
        for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 1);
        step(0, 0, 0, 1, 1);
        // refill to the held limit, then drain everything in order
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 1);
        // R8: yield with data pending
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 6);
        step(0, 1, 0, 0, 6);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 6);

        // Mixed random traffic; also wraps the 4-bit handoff counter (R10)
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(99) < 60), ($urandom_range(99) < 5),
                 ($urandom_range(99) < 70), ($urandom_range(99) < 5),
                 int'($urandom_range(7)));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule